// File: doc/BRIEF.md
# Multi-mode cartridge ROM bank mapper

This block sits between a CPU cartridge slot and a large parallel flash. It turns every 16-bit CPU address into a 23-bit flash address. The CPU chooses one of five banking schemes: two Konami-style schemes (one with a sound-chip window, one without), ASCII with 8K pages, ASCII with 16K pages, and a linear scheme that maps the whole 64K space in 16K pages. The block holds four bank registers, a scheme register, a 10-bit global bank offset and a configuration register. The CPU writes all of them through fixed memory addresses in the slot.

A write never stops at the registers. The flash address is translated from the register contents that held before the write. The same write is then passed on to the flash when flash writes are enabled, so the flash command sequencer, which lies outside this block, sees every store. A disk mode points banks 0 and 1 at a fixed kernel area when they hold their power-on values. Reads that fall outside the mapped window are flagged, and the slot returns 0xFF for them.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, bank registers 0..3 hold 0, 1, 2 and 3. The scheme register and the offset are 0. The configuration register is 0x03, so flash writes are enabled and block protect is on.
- R2: Scheme register (address 0x7FFF), bits 7:6: 00 selects Konami-with-sound, 01 selects linear 64K, 10 selects ASCII-8, 11 selects ASCII-16. With bits 7:6 = 00, bit 5 = 1 selects plain Konami. In linear mode, page p = addr[15:14] with 16K pages, and all addresses are mapped. In the other modes, only 0x4000–0xBFFF is mapped, in 8K pages with p = (addr>>13) - 2.
- R3: Flash address = (bank × page size + offset within the page + 0x010000) mod 2^23.
- R4: The 10-bit offset takes bits 7:0 from a write to 0x7FFD and bits 9:8 from data bits 1:0 of a write to 0x7FFE. It is added to the bank number before the address is formed.
- R5: Disk mode is configuration bit 4. In disk mode, page 0 uses bank 0x3FA when its register holds 0, and page 1 uses bank 0x3FB when its register holds 1. The offset is not added in these two cases.
- R6: `unmapped` is high only while `cpu_rd` is high and the address lies outside the mapped window.
- R7: In ASCII-8, a write in 0x6000–0x7FFF loads the bank register whose index is addr[12:11].
- R8: In ASCII-16, a write in 0x6000–0x67FF loads banks 0 and 1 with 2v and 2v+1. A write in 0x7000–0x77FF does the same for banks 2 and 3. Results are taken modulo 256.
- R9: In Konami-with-sound, a write in the 8K window whose addr[12:11] = 10 loads the bank register of its page. When scheme bit 0 is set, the value is masked to 6 bits.
- R10: In plain Konami, only writes in 0x5000–0x57FF and 0x6000–0xBFFF load the bank register of their page. Scheme bit 3 blocks writes below 0x6000, and scheme bit 0 masks the value to 5 bits.
- R11: Once set, scheme bit 2 freezes the scheme register, scheme bit 1 freezes the bank and offset registers, and configuration bit 7 freezes the configuration register (address 0x7FFC).
- R12: `flash_wr` follows `cpu_wr` when configuration bit 0 is 1 and the address is mapped, including writes to register addresses. In that cycle, `flash_addr` uses the register values from before the write.
- R13: `flash_protect` reflects configuration bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, one cycle per store |
| flash_addr | output | 23 | Translated flash address |
| flash_wr | output | 1 | Write passed to the flash |
| flash_protect | output | 1 | Block-protect level for the flash |
| unmapped | output | 1 | Read outside the mapped window |

## Verification
The assertions check five things on every cycle. The three lock bits keep their registers frozen. An ASCII-16 pair write leaves bank 1 one above bank 0. A masked Konami-with-sound write never leaves the top two bank bits set. `flash_wr` and `unmapped` only appear with their strobes and inside the enable conditions.

Other behaviour can only be shown by the bench scenarios, which sweep the address space in every scheme against an arithmetic model. These cover the address arithmetic and its 8 MB wrap, the offset split, the disk-kernel remap, the per-scheme write decode, and the way register addresses double as bank-write addresses.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  parameter int CPU_AW   = 16;
  parameter int DATA_W   = 8;
  parameter int NBANK    = 4;
  parameter int BANK_W   = 8;
  parameter int OFF_W    = 10;
  parameter int FLASH_AW = 23;
  parameter int PG8_W    = 13;
  parameter int PG16_W   = 14;

  localparam int PG_IDX_W = $clog2(NBANK);
  localparam int SUM_W    = ((BANK_W > OFF_W) ? BANK_W : OFF_W) + 1;
  localparam int WIDE_W   = SUM_W + PG16_W;

  localparam logic [FLASH_AW-1:0] FLASH_BASE = FLASH_AW'(24'h01_0000);
  localparam logic [SUM_W-1:0]    DISK_BANK0 = SUM_W'(11'h3FA);
  localparam logic [SUM_W-1:0]    DISK_BANK1 = SUM_W'(11'h3FB);

  localparam logic [CPU_AW-1:0] A_CFG    = 16'h7FFC;
  localparam logic [CPU_AW-1:0] A_OFF_LO = 16'h7FFD;
  localparam logic [CPU_AW-1:0] A_OFF_HI = 16'h7FFE;
  localparam logic [CPU_AW-1:0] A_MODE   = 16'h7FFF;

  typedef enum logic [2:0] {
    MAP_KSND   = 3'd0,
    MAP_KONAMI = 3'd1,
    MAP_LIN64  = 3'd2,
    MAP_ASC8   = 3'd3,
    MAP_ASC16  = 3'd4
  } map_mode_e;

  function automatic map_mode_e decode_mode(input logic [DATA_W-1:0] mr);
    case (mr[7:6])
      2'b00:   return mr[5] ? MAP_KONAMI : MAP_KSND;
      2'b01:   return MAP_LIN64;
      2'b10:   return MAP_ASC8;
      default: return MAP_ASC16;
    endcase
  endfunction

  // 8K window 0x4000-0xBFFF
  function automatic logic in_win8(input logic [CPU_AW-1:0] a);
    return (a[15:14] == 2'b01) || (a[15:14] == 2'b10);
  endfunction

  // page index (addr>>13)-2 inside the 8K window
  function automatic logic [PG_IDX_W-1:0] page8(input logic [CPU_AW-1:0] a);
    return {a[15], a[13]};
  endfunction

  function automatic logic [FLASH_AW-1:0] flash_map(
      input logic [SUM_W-1:0]  bank,
      input logic [PG16_W-1:0] inpage,
      input logic              is16k);
    logic [WIDE_W-1:0] t;
    if (is16k) t = WIDE_W'(bank) << PG16_W;
    else       t = WIDE_W'(bank) << PG8_W;
    t = t + WIDE_W'(inpage) + WIDE_W'(FLASH_BASE);
    return t[FLASH_AW-1:0];
  endfunction
endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile
  import cbm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CPU_AW-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NBANK-1:0][BANK_W-1:0] bank_q,
  output logic [DATA_W-1:0]            mode_q,
  output logic [OFF_W-1:0]             off_q,
  output logic [DATA_W-1:0]            cfg_q
);
  localparam logic [DATA_W-1:0] CFG_RST = 8'h03;

  map_mode_e                   mode;
  logic [NBANK-1:0]            bank_we;
  logic [NBANK-1:0][BANK_W-1:0] bank_wd;
  logic [PG_IDX_W-1:0]         wr_pg;
  logic                        bank_open;
  logic                        ksnd_mask_evt;
  logic                        asc16_lo_evt;
  logic                        konami_ok;
  logic [BANK_W-1:0]           dbl;

  assign mode      = decode_mode(mode_q);
  assign wr_pg     = page8(addr);
  assign bank_open = wr_en && !mode_q[1] && in_win8(addr);
  assign dbl       = BANK_W'({wdata, 1'b0});
  assign konami_ok = !(addr < 16'h5000 || (addr >= 16'h5800 && addr < 16'h6000))
                     && !(mode_q[3] && addr < 16'h6000);

  always_comb begin
    bank_we       = '0;
    bank_wd       = '0;
    ksnd_mask_evt = 1'b0;
    asc16_lo_evt  = 1'b0;
    if (bank_open) begin
      case (mode)
        MAP_KSND: if (addr[12:11] == 2'b10) begin
          bank_we[wr_pg] = 1'b1;
          bank_wd[wr_pg] = mode_q[0] ? (wdata & 8'h3F) : wdata;
          ksnd_mask_evt  = mode_q[0];
        end
        MAP_KONAMI: if (konami_ok) begin
          bank_we[wr_pg] = 1'b1;
          bank_wd[wr_pg] = mode_q[0] ? (wdata & 8'h1F) : wdata;
        end
        MAP_LIN64: begin
          bank_we[wr_pg] = 1'b1;
          bank_wd[wr_pg] = wdata;
        end
        MAP_ASC8: if (addr[15:13] == 3'b011) begin
          bank_we[addr[12:11]] = 1'b1;
          bank_wd[addr[12:11]] = wdata;
        end
        default: begin
          if (addr[15:11] == 5'b01100) begin
            bank_we[1:0] = 2'b11;
            bank_wd[0]   = dbl;
            bank_wd[1]   = dbl + 1'b1;
            asc16_lo_evt = 1'b1;
          end
          if (addr[15:11] == 5'b01110) begin
            bank_we[3:2] = 2'b11;
            bank_wd[2]   = dbl;
            bank_wd[3]   = dbl + 1'b1;
          end
        end
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NBANK; gi++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)            bank_q[gi] <= BANK_W'(gi);
        else if (bank_we[gi])  bank_q[gi] <= bank_wd[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      off_q  <= '0;
      cfg_q  <= CFG_RST;
    end else if (wr_en) begin
      if (!cfg_q[7] && addr == A_CFG)    cfg_q  <= wdata;
      if (!mode_q[2] && addr == A_MODE)  mode_q <= wdata;
      if (!mode_q[1] && addr == A_OFF_LO) off_q[7:0] <= wdata;
      if (!mode_q[1] && addr == A_OFF_HI) off_q[OFF_W-1:8] <= wdata[OFF_W-9:0];
    end
  end

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[2] |=> $stable(mode_q)); // R11
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] |=> $stable(cfg_q)); // R11
  AST_BANK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |=> ($stable(bank_q) && $stable(off_q))); // R11
  AST_ASC16_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    asc16_lo_evt |=> (bank_q[1] == bank_q[0] + 1'b1)); // R8
  AST_KSND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ksnd_mask_evt |=> (bank_q[$past(wr_pg)][7:6] == 2'b00)); // R9
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
  import cbm_pkg::*;
(
  input  logic [CPU_AW-1:0]            addr,
  input  logic [NBANK-1:0][BANK_W-1:0] bank_q,
  input  map_mode_e                    mode,
  input  logic [OFF_W-1:0]             off_q,
  input  logic                         disk,
  output logic [FLASH_AW-1:0]          flash_addr,
  output logic                         in_window
);
  logic                is16k;
  logic [PG_IDX_W-1:0] pg;
  logic [PG16_W-1:0]   inpage;
  logic [BANK_W-1:0]   raw;
  logic [SUM_W-1:0]    sel;

  assign is16k = (mode == MAP_LIN64);

  always_comb begin
    if (is16k) begin
      pg        = addr[15:14];
      inpage    = addr[PG16_W-1:0];
      in_window = 1'b1;
    end else begin
      pg        = page8(addr);
      inpage    = PG16_W'(addr[PG8_W-1:0]);
      in_window = in_win8(addr);
    end
    raw = bank_q[pg];
    if (disk && pg == 0 && raw == 0)      sel = DISK_BANK0;
    else if (disk && pg == 1 && raw == 1) sel = DISK_BANK1;
    else                                  sel = SUM_W'(raw) + SUM_W'(off_q);
    flash_addr = flash_map(sel, inpage, is16k);
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_wr,
  output logic                flash_protect,
  output logic                unmapped
);
  logic [NBANK-1:0][BANK_W-1:0] bank_q;
  logic [DATA_W-1:0]            mode_q;
  logic [OFF_W-1:0]             off_q;
  logic [DATA_W-1:0]            cfg_q;
  logic                         in_window;
  map_mode_e                    mode;

  assign mode = decode_mode(mode_q);

  cbm_regfile u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cpu_wr),
    .addr   (cpu_addr),
    .wdata  (cpu_wdata),
    .bank_q (bank_q),
    .mode_q (mode_q),
    .off_q  (off_q),
    .cfg_q  (cfg_q)
  );

  cbm_xlate u_xlate (
    .addr       (cpu_addr),
    .bank_q     (bank_q),
    .mode       (mode),
    .off_q      (off_q),
    .disk       (cfg_q[4]),
    .flash_addr (flash_addr),
    .in_window  (in_window)
  );

  assign flash_wr      = cpu_wr && cfg_q[0] && in_window;
  assign unmapped      = cpu_rd && !in_window;
  assign flash_protect = cfg_q[1];

  AST_FLASHWR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_wr |-> (cpu_wr && cfg_q[0] && (mode == MAP_LIN64 || in_win8(cpu_addr)))); // R12
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (cpu_rd && !flash_wr && mode != MAP_LIN64)); // R6
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [22:0] flash_addr;
  logic        flash_wr;
  logic        flash_protect;
  logic        unmapped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mb[4];
  int mmode, moff, mcfg;

  always #5 clk = ~clk;

  cart_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .flash_addr(flash_addr),
    .flash_wr(flash_wr), .flash_protect(flash_protect), .unmapped(unmapped)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_flash(input int a);
    int p, sz, b, kind;
    kind = (mmode >> 6) & 3;
    if (kind == 1) begin
      sz = 16384; p = a / 16384;
    end else begin
      if (a < 'h4000 || a >= 'hC000) return -1;
      sz = 8192; p = a / 8192 - 2;
    end
    b = mb[p];
    if (((mcfg >> 4) & 1) == 1 && p == 0 && b == 0)      b = 'h3FA;
    else if (((mcfg >> 4) & 1) == 1 && p == 1 && b == 1) b = 'h3FB;
    else b = b + moff;
    return (b * sz + (a % sz) + 'h10000) % (1 << 23);
  endfunction

  task automatic model_write(input int a, input int v);
    int om, nb[4], kind, p;
    om = mmode;
    for (int i = 0; i < 4; i++) nb[i] = mb[i];
    kind = (om >> 6) & 3;
    p = a / 8192 - 2;
    if (((om >> 1) & 1) == 0 && a >= 'h4000 && a < 'hC000) begin
      if (kind == 0 && ((om >> 5) & 1) == 0) begin
        if ((a & 'h1800) == 'h1000) nb[p] = (om & 1) ? (v & 'h3F) : v;
      end else if (kind == 0) begin
        if (!(((om >> 3) & 1) == 1 && a < 'h6000) &&
            !(a < 'h5000 || (a >= 'h5800 && a < 'h6000)))
          nb[p] = (om & 1) ? (v & 'h1F) : v;
      end else if (kind == 1) begin
        nb[p] = v;
      end else if (kind == 2) begin
        if (a >= 'h6000 && a < 'h8000) nb[(a >> 11) & 3] = v;
      end else begin
        if (a >= 'h6000 && a < 'h6800) begin nb[0] = (2*v) & 255; nb[1] = (2*v+1) & 255; end
        if (a >= 'h7000 && a < 'h7800) begin nb[2] = (2*v) & 255; nb[3] = (2*v+1) & 255; end
      end
    end
    if (((mcfg >> 7) & 1) == 0 && a == 'h7FFC) mcfg = v;
    if (((om >> 1) & 1) == 0 && a == 'h7FFD) moff = (moff & 'h300) | v;
    if (((om >> 1) & 1) == 0 && a == 'h7FFE) moff = (moff & 'hFF) | ((v & 3) << 8);
    if (((om >> 2) & 1) == 0 && a == 'h7FFF) mmode = v;
    for (int i = 0; i < 4; i++) mb[i] = nb[i];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) mb[i] = i;
    mmode = 0; moff = 0; mcfg = 3;
  endtask

  // write: flash strobe and pre-update address sampled before the edge (R12)
  task automatic bus_write(input int a, input int v);
    int e;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(v); cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    e = exp_flash(a);
    check("R12 flash_wr", int'(flash_wr), (e >= 0 && (mcfg & 1)) ? 1 : 0);
    if (e >= 0) check("R12 write address", int'(flash_addr), e);
    @(posedge clk);
    #1 cpu_wr = 1'b0;
    model_write(a, v);
  endtask

  task automatic read_at(input string req, input int a);
    int e;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
    e = exp_flash(a);
    if (e < 0) check({req, " R6 unmapped"}, int'(unmapped), 1);
    else begin
      check(req, int'(flash_addr), e);
      check({req, " R6 mapped"}, int'(unmapped), 0);
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 65536; a += 1024) read_at(req, a + ((a >> 10) * 7));
    read_at(req, 'hFFFF);
    @(negedge clk) cpu_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state and R2/R3 default translation
    check("R1 protect", int'(flash_protect), 1);
    read_at("R1 bank0", 'h4000);
    check("R1 bank0 abs", int'(flash_addr), 'h10000);
    read_at("R1 bank3", 'hA000);
    check("R1 bank3 abs", int'(flash_addr), 'h16000);
    sweep("R2 R3 reset sweep");

    // R9 Konami with sound
    bus_write('h5000, 'h85);
    bus_write('h4000, 'h11);        // not a bank register address
    bus_write('h7FFF, 'h01);        // mask on
    bus_write('h7000, 'hC7);
    bus_write('hB000, 'hFE);
    read_at("R9 masked", 'h6000);
    check("R9 masked abs", int'(flash_addr), 'h10000 + 7 * 8192);
    sweep("R9 ksnd sweep");

    // R10 plain Konami
    do_reset();
    bus_write('h7FFF, 'h20);
    bus_write('h4800, 'h33);
    bus_write('h5000, 'h44);
    bus_write('h5800, 'h55);
    bus_write('h6000, 'h66);
    bus_write('h9000, 'h77);
    bus_write('hB000, 'hEE);
    sweep("R10 konami sweep");
    bus_write('h7FFF, 'h29);        // block + mask, also loads bank1
    bus_write('h5000, 'h12);
    bus_write('h7000, 'hFF);
    read_at("R10 blocked", 'h4000);
    check("R10 blocked abs", int'(flash_addr), 'h10000 + 'h44 * 8192);
    sweep("R10 konami mask sweep");

    // R2 linear 64K
    do_reset();
    bus_write('h7FFF, 'h40);
    bus_write('h4000, 'h09);
    bus_write('h6000, 'h0A);
    bus_write('h8000, 'h0B);
    bus_write('hA000, 'hFF);
    sweep("R2 lin64 sweep");
    // R3 wrap at 8 MB with large offset
    bus_write('h7FFD, 'hFF);
    bus_write('h7FFE, 'h03);
    read_at("R3 wrap", 'hC123);
    check("R3 wrap abs", int'(flash_addr), (('hFF + 'h3FF) * 16384 + 'h0123 + 'h10000) % (1 << 23));
    sweep("R3 R4 lin64 offset sweep");

    // R7 ASCII-8
    do_reset();
    bus_write('h7FFF, 'h80);
    bus_write('h6000, 'h21);
    bus_write('h6800, 'h22);
    bus_write('h7000, 'h23);
    bus_write('h7800, 'h24);
    bus_write('h5000, 'h99);        // outside decode
    sweep("R7 asc8 sweep");
    // R4 offset split
    bus_write('h7FFD, 'h34);
    bus_write('h7FFE, 'hFE);        // only bits 1:0 used
    read_at("R4 offset", 'h4000);
    check("R4 offset abs", int'(flash_addr), ('h21 + 'h234) * 8192 + 'h10000);
    sweep("R4 asc8 offset sweep");

    // R8 ASCII-16
    do_reset();
    bus_write('h7FFF, 'hC0);
    bus_write('h6000, 'h81);
    bus_write('h7000, 'h05);
    bus_write('h6800, 'h44);
    read_at("R8 pair", 'h6000);
    check("R8 pair abs", int'(flash_addr), 'h03 * 8192 + 'h10000);
    sweep("R8 asc16 sweep");

    // R5 disk mode
    do_reset();
    bus_write('h7FFD, 'h10);
    bus_write('h7FFC, 'h13);
    read_at("R5 disk b0", 'h4001);
    check("R5 disk b0 abs", int'(flash_addr), ('h3FA * 8192 + 1 + 'h10000) % (1 << 23));
    read_at("R5 disk b1", 'h6002);
    check("R5 disk b1 abs", int'(flash_addr), ('h3FB * 8192 + 2 + 'h10000) % (1 << 23));
    bus_write('h5000, 'h02);
    sweep("R5 disk sweep");

    // R12 / R13 write enable and protect off
    do_reset();
    bus_write('h7FFC, 'h00);
    check("R13 protect off", int'(flash_protect), 0);
    bus_write('h8000, 'h5A);
    bus_write('h2000, 'h5A);
    bus_write('h7FFC, 'h01);
    bus_write('h2000, 'h5A);
    bus_write('h8000, 'h5A);

    // R11 locks
    do_reset();
    bus_write('h7FFC, 'h81);
    bus_write('h7FFC, 'h13);
    check("R11 cfg lock protect", int'(flash_protect), 0);
    bus_write('h7FFF, 'h86);
    bus_write('h7FFF, 'h40);
    bus_write('h7FFD, 'h55);
    bus_write('h6000, 'h3C);
    sweep("R11 lock sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule